// File: doc/BRIEF.md
# Bridge Header Configuration Register File

This block is the register file behind the type-1 configuration header of a PCI-to-PCI bridge. A configuration agent sends one request per cycle. Each request carries a byte offset into the header, an access size of 1, 2 or 4 bytes, a read/write flag and write data. The block answers every request one cycle later with a response strobe, read data and an error flag. Reads of sub-dword size are extracted from the addressed dword. Writes of sub-dword size are merged into the current dword before any field is updated.

The identifiers, class code, header type and cache line size are fixed. The command word, both BAR words, the four bus-number bytes and the I/O and memory window registers are writable. A one-cycle event goes out whenever a write makes the downstream I/O window or memory window need recomputing, so that the window-programming logic next to the block can react. The secondary bus number is driven out continuously. An input strap says whether the bridge has an I/O port at all. When it does not, the I/O enable cannot be set and the I/O window register reads as zero.

Top module: `bridge_cfg_space`

## Requirements
- R1: After reset the header reads as follows:
  - offset 0x00 = {DEVICE_ID, VENDOR_ID}
  - offset 0x08 = {CLASS_CODE (default 16'h0604), 8'h00, REVISION}
  - offset 0x0C = 32'h0001_0010 (header type 1, cache line 0x10)
  - offset 0x1C = 32'h0000_0101 when an I/O port exists
  - every other defined offset reads as zero
- R2: Writes to offsets 0x00, 0x08 and 0x0C are accepted without error and change nothing.
- R3: Offset 0x18 is fully writable as {secondary latency, subordinate bus, secondary bus, primary bus}, from bit 31 down. `secBus` always equals bits [15:8] of it.
- R4: Offsets 0x10 and 0x14 are two fully writable 32-bit BAR words.
- R5: A write to offset 0x1C stores byte 0 as I/O base and byte 1 as I/O limit, each with bit 0 forced to 1 (32-bit I/O). Bits [31:16] of this offset read as zero.
- R6: While `ioPortPresent` is low, a write to command bit 0 (I/O enable) stores 0, and offset 0x1C reads as zero.
- R7: Offset 0x20 holds {memory limit, memory base}. Offset 0x30 holds {I/O limit upper, I/O base upper}. Both are fully writable.
- R8: Offsets 0x24, 0x38 and 0x3C read as zero and ignore writes. Offsets 0x28, 0x2C, 0x34 and any offset of 0x40 or above answer with `rspErr`=1 and data 0, and change no state.
- R9: A read returns (dword >> 8*offset[1:0]), masked to 8 bits for size 1 and to 16 bits for size 2. A size other than 1, 2 or 4, or size 4 with offset[1:0] not zero, answers with `rspErr`=1, returns data 0 and changes no state.
- R10: A write of size 1 or 2 replaces only the addressed byte lanes, starting at 8*offset[1:0], and keeps the other bits of the dword.
- R11: A command write (offset 0x04) raises `ioChange` only if bit 0 changed, and `memChange` only if bit 1 changed. Both can rise in the same cycle.
- R12: Every accepted write to 0x1C or 0x30 raises `ioChange`. Every accepted write to 0x20 raises `memChange`. The pulses last one cycle and appear together with the response.
- R13: `rspValid` is high exactly one cycle after each `reqValid`. Back-to-back requests are served every cycle, and data and pulses are zero when no request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioPortPresent | input | 1 | High when the bridge has an I/O port |
| reqValid | input | 1 | Request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte offset into the header |
| reqSize | input | 3 | Access size in bytes |
| reqWData | input | 32 | Write data, right-aligned |
| rspValid | output | 1 | Response strobe, one cycle after the request |
| rspData | output | 32 | Read data, right-aligned |
| rspErr | output | 1 | Bad offset or bad size |
| ioChange | output | 1 | One-cycle I/O window recompute event |
| memChange | output | 1 | One-cycle memory window recompute event |
| secBus | output | 8 | Current secondary bus number |

## Verification
A single command write that flips both the I/O and the memory enable must raise `ioChange` and `memChange` in the same cycle. The bench provokes this by writing 0x0003 over a zero command word. It then writes the same value again, which must give no pulse, and then flips only one bit. With the I/O port strap low, the I/O-enable half of the pair is suppressed while the memory half still fires. The behavioural model predicts each pulse from the old and new enable bits. It is compared against both outputs on every cycle, together with the response and the secondary bus number.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;

  localparam int DW = 32;
  localparam int IDX_W = 4;

  // Dword index of each header word (offset / 4)
  localparam logic [IDX_W-1:0] IDX_ID    = 4'd0;
  localparam logic [IDX_W-1:0] IDX_CMD   = 4'd1;
  localparam logic [IDX_W-1:0] IDX_CLASS = 4'd2;
  localparam logic [IDX_W-1:0] IDX_HDR   = 4'd3;
  localparam logic [IDX_W-1:0] IDX_BAR0  = 4'd4;
  localparam logic [IDX_W-1:0] IDX_BAR1  = 4'd5;
  localparam logic [IDX_W-1:0] IDX_BUS   = 4'd6;
  localparam logic [IDX_W-1:0] IDX_IOLO  = 4'd7;
  localparam logic [IDX_W-1:0] IDX_MEM   = 4'd8;
  localparam logic [IDX_W-1:0] IDX_PREF  = 4'd9;
  localparam logic [IDX_W-1:0] IDX_IOUP  = 4'd12;
  localparam logic [IDX_W-1:0] IDX_ROM   = 4'd14;
  localparam logic [IDX_W-1:0] IDX_INTR  = 4'd15;

  typedef struct packed {
    logic cmd;
    logic bar0;
    logic bar1;
    logic bus;
    logic ioLo;
    logic mem;
    logic ioUp;
  } wrStrobes_t;

  function automatic logic idxDefined(input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_ID, IDX_CMD, IDX_CLASS, IDX_HDR, IDX_BAR0, IDX_BAR1, IDX_BUS,
      IDX_IOLO, IDX_MEM, IDX_PREF, IDX_IOUP, IDX_ROM, IDX_INTR: idxDefined = 1'b1;
      default: idxDefined = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/bcfg_ctrl.sv
module bcfg_ctrl
  import bcfg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  input  logic [DW-1:0]     reqWData,
  input  logic [DW-1:0]     curWord,
  output logic [IDX_W-1:0]  dwIdx,
  output wrStrobes_t        wrStb,
  output logic [DW-1:0]     mergedWord,
  output logic              rspValid,
  output logic [DW-1:0]     rspData,
  output logic              rspErr
);

  localparam int HDR_BYTES_LOG2 = 6;

  logic [1:0]    lane;
  logic [4:0]    shiftAmt;
  logic          inRange;
  logic          sizeOk;
  logic          regOk;
  logic          accept;
  logic [DW-1:0] laneMask;
  logic [DW-1:0] readData;

  always_comb begin
    dwIdx    = reqAddr[IDX_W+1:2];
    lane     = reqAddr[1:0];
    shiftAmt = {lane, 3'b000};
    inRange  = (reqAddr >> HDR_BYTES_LOG2) == '0;
    case (reqSize)
      3'd1:    sizeOk = 1'b1;
      3'd2:    sizeOk = 1'b1;
      3'd4:    sizeOk = (lane == 2'd0);
      default: sizeOk = 1'b0;
    endcase
    case (reqSize)
      3'd1:    laneMask = 32'h0000_00ff;
      3'd2:    laneMask = 32'h0000_ffff;
      default: laneMask = 32'hffff_ffff;
    endcase
    regOk      = inRange && idxDefined(dwIdx);
    accept     = reqValid && sizeOk && regOk;
    readData   = (curWord >> shiftAmt) & laneMask;
    mergedWord = (curWord & ~(laneMask << shiftAmt)) | ((reqWData & laneMask) << shiftAmt);

    wrStb = '0;
    if (accept && reqWrite) begin
      wrStb.cmd  = (dwIdx == IDX_CMD);
      wrStb.bar0 = (dwIdx == IDX_BAR0);
      wrStb.bar1 = (dwIdx == IDX_BAR1);
      wrStb.bus  = (dwIdx == IDX_BUS);
      wrStb.ioLo = (dwIdx == IDX_IOLO);
      wrStb.mem  = (dwIdx == IDX_MEM);
      wrStb.ioUp = (dwIdx == IDX_IOUP);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= reqValid;
      rspErr   <= reqValid && !(sizeOk && regOk);
      rspData  <= (accept && !reqWrite) ? readData : '0;
    end
  end

  // R13
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R13
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && rspData == '0));

  // R8
  err_no_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspValid && rspData == '0));

  // R9
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrStb));

endmodule

// File: rtl/bcfg_dp.sv
module bcfg_dp
  import bcfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h1234,
  parameter logic [15:0] DEVICE_ID  = 16'h5678,
  parameter logic [7:0]  REVISION   = 8'h03,
  parameter logic [15:0] CLASS_CODE = 16'h0604
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ioPortPresent,
  input  logic [IDX_W-1:0] dwIdx,
  input  wrStrobes_t       wrStb,
  input  logic [DW-1:0]    mergedWord,
  output logic [DW-1:0]    curWord,
  output logic             ioChange,
  output logic             memChange,
  output logic [7:0]       secBus
);

  localparam logic [7:0] HEADER_TYPE = 8'h01;
  localparam logic [7:0] CACHE_LINE  = 8'h10;
  localparam logic [7:0] IO_RANGE32  = 8'h01;
  localparam int         CMD_W       = 16;
  localparam int         IOEN_BIT    = 0;
  localparam int         MEMEN_BIT   = 1;

  logic [CMD_W-1:0] cmdReg;
  logic [DW-1:0]    bar0Reg, bar1Reg;
  logic [7:0]       priBus, secBusReg, subBus, secLat;
  logic [7:0]       ioBase, ioLimit;
  logic [15:0]      memBase, memLimit;
  logic [15:0]      ioBaseUp, ioLimitUp;
  logic [CMD_W-1:0] newCmd;
  logic             ioToggle, memToggle;

  always_comb begin
    case (dwIdx)
      IDX_ID:    curWord = {DEVICE_ID, VENDOR_ID};
      IDX_CMD:   curWord = {16'h0000, cmdReg};
      IDX_CLASS: curWord = {CLASS_CODE, 8'h00, REVISION};
      IDX_HDR:   curWord = {8'h00, HEADER_TYPE, 8'h00, CACHE_LINE};
      IDX_BAR0:  curWord = bar0Reg;
      IDX_BAR1:  curWord = bar1Reg;
      IDX_BUS:   curWord = {secLat, subBus, secBusReg, priBus};
      IDX_IOLO:  curWord = ioPortPresent ? {16'h0000, ioLimit, ioBase} : '0;
      IDX_MEM:   curWord = {memLimit, memBase};
      IDX_IOUP:  curWord = {ioLimitUp, ioBaseUp};
      default:   curWord = '0;
    endcase
  end

  always_comb begin
    newCmd = mergedWord[CMD_W-1:0];
    if (!ioPortPresent) newCmd[IOEN_BIT] = 1'b0;
    ioToggle  = newCmd[IOEN_BIT]  != cmdReg[IOEN_BIT];
    memToggle = newCmd[MEMEN_BIT] != cmdReg[MEMEN_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg    <= '0;
      bar0Reg   <= '0;
      bar1Reg   <= '0;
      priBus    <= '0;
      secBusReg <= '0;
      subBus    <= '0;
      secLat    <= '0;
      ioBase    <= IO_RANGE32;
      ioLimit   <= IO_RANGE32;
      memBase   <= '0;
      memLimit  <= '0;
      ioBaseUp  <= '0;
      ioLimitUp <= '0;
      ioChange  <= 1'b0;
      memChange <= 1'b0;
    end else begin
      if (wrStb.cmd)  cmdReg  <= newCmd;
      if (wrStb.bar0) bar0Reg <= mergedWord;
      if (wrStb.bar1) bar1Reg <= mergedWord;
      if (wrStb.bus) begin
        priBus    <= mergedWord[7:0];
        secBusReg <= mergedWord[15:8];
        subBus    <= mergedWord[23:16];
        secLat    <= mergedWord[31:24];
      end
      if (wrStb.ioLo) begin
        ioBase  <= mergedWord[7:0]  | IO_RANGE32;
        ioLimit <= mergedWord[15:8] | IO_RANGE32;
      end
      if (wrStb.mem) begin
        memBase  <= mergedWord[15:0];
        memLimit <= mergedWord[31:16];
      end
      if (wrStb.ioUp) begin
        ioBaseUp  <= mergedWord[15:0];
        ioLimitUp <= mergedWord[31:16];
      end
      ioChange  <= (wrStb.cmd && ioToggle) || wrStb.ioLo || wrStb.ioUp;
      memChange <= (wrStb.cmd && memToggle) || wrStb.mem;
    end
  end

  assign secBus = secBusReg;

  // R6
  io_enable_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdReg[IOEN_BIT]) |-> $past(ioPortPresent));

  // R3
  secbus_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrStb.bus |=> $stable(secBus));

  // R12
  io_pulse_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    ioChange |-> $past(wrStb.cmd || wrStb.ioLo || wrStb.ioUp));

  // R11
  mem_pulse_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    memChange |-> $past(wrStb.cmd || wrStb.mem));

  // R5
  io_range_type_chk: assert property (@(posedge clk) disable iff (!rstN)
    ioBase[0] && ioLimit[0]);

endmodule

// File: rtl/bridge_cfg_space.sv
module bridge_cfg_space
  import bcfg_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter logic [15:0] VENDOR_ID  = 16'h1234,
  parameter logic [15:0] DEVICE_ID  = 16'h5678,
  parameter logic [7:0]  REVISION   = 8'h03,
  parameter logic [15:0] CLASS_CODE = 16'h0604
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioPortPresent,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  input  logic [31:0]       reqWData,
  output logic              rspValid,
  output logic [31:0]       rspData,
  output logic              rspErr,
  output logic              ioChange,
  output logic              memChange,
  output logic [7:0]        secBus
);

  logic [IDX_W-1:0] dwIdx;
  wrStrobes_t       wrStb;
  logic [DW-1:0]    mergedWord;
  logic [DW-1:0]    curWord;

  bcfg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqAddr    (reqAddr),
    .reqSize    (reqSize),
    .reqWData   (reqWData),
    .curWord    (curWord),
    .dwIdx      (dwIdx),
    .wrStb      (wrStb),
    .mergedWord (mergedWord),
    .rspValid   (rspValid),
    .rspData    (rspData),
    .rspErr     (rspErr)
  );

  bcfg_dp #(
    .VENDOR_ID  (VENDOR_ID),
    .DEVICE_ID  (DEVICE_ID),
    .REVISION   (REVISION),
    .CLASS_CODE (CLASS_CODE)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ioPortPresent (ioPortPresent),
    .dwIdx         (dwIdx),
    .wrStb         (wrStb),
    .mergedWord    (mergedWord),
    .curWord       (curWord),
    .ioChange      (ioChange),
    .memChange     (memChange),
    .secBus        (secBus)
  );

  // R8
  err_no_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (!ioChange && !memChange));

endmodule

// File: tb/bridge_cfg_space_test.sv
module bridge_cfg_space_test;

  localparam logic [15:0] VEN = 16'hBEEF;
  localparam logic [15:0] DEV = 16'h7A11;
  localparam logic [7:0]  REV = 8'h5C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioPres = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [2:0]  reqSize = 3'd4;
  logic [31:0] reqWData = '0;
  logic        rspValid, rspErr, ioChange, memChange;
  logic [31:0] rspData;
  logic [7:0]  secBus;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // behavioural model state
  logic [15:0] mCmd;
  logic [31:0] mBar0, mBar1, mBus, mMem, mIoUp;
  logic [7:0]  mIoB, mIoL;

  always #5 clk = ~clk;

  bridge_cfg_space #(
    .ADDR_W(8), .VENDOR_ID(VEN), .DEVICE_ID(DEV), .REVISION(REV), .CLASS_CODE(16'h0604)
  ) uut (
    .clk(clk), .rstN(rstN), .ioPortPresent(ioPres),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqWData(reqWData), .rspValid(rspValid), .rspData(rspData), .rspErr(rspErr),
    .ioChange(ioChange), .memChange(memChange), .secBus(secBus)
  );

  function automatic logic [31:0] mRead(input logic [3:0] idx);
    case (idx)
      4'd0:  return {DEV, VEN};
      4'd1:  return {16'h0, mCmd};
      4'd2:  return {16'h0604, 8'h00, REV};
      4'd3:  return 32'h0001_0010;
      4'd4:  return mBar0;
      4'd5:  return mBar1;
      4'd6:  return mBus;
      4'd7:  return ioPres ? {16'h0, mIoL, mIoB} : 32'h0;
      4'd8:  return mMem;
      4'd12: return mIoUp;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit known(input logic [3:0] idx);
    return (idx <= 4'd9) || idx == 4'd12 || idx == 4'd14 || idx == 4'd15;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic compare(input string tag, input bit eV, input bit eE, input logic [31:0] eD,
                         input bit eI, input bit eM);
    checks++;
    if (rspValid !== eV || rspErr !== eE || rspData !== eD || ioChange !== eI ||
        memChange !== eM || secBus !== mBus[15:8]) begin
      fails++;
      $display("FAIL %s: got v=%b e=%b d=%h io=%b mem=%b sec=%h expected v=%b e=%b d=%h io=%b mem=%b sec=%h",
               tag, rspValid, rspErr, rspData, ioChange, memChange, secBus,
               eV, eE, eD, eI, eM, mBus[15:8]);
    end
  endtask

  // one request; called at a falling edge, returns at the next falling edge
  task automatic xact(input bit wr, input logic [7:0] addr, input logic [2:0] size,
                      input logic [31:0] data, input string tag);
    logic [3:0]  idx = addr[5:2];
    int          sh = 8 * int'(addr[1:0]);
    logic [31:0] msk = (size == 3'd1) ? 32'hff : (size == 3'd2) ? 32'hffff : 32'hffff_ffff;
    bit          szOk = (size == 3'd1) || (size == 3'd2) || (size == 3'd4 && addr[1:0] == 2'd0);
    bit          ok = (addr < 8'h40) && known(idx) && szOk;
    logic [31:0] cur = mRead(idx);
    logic [31:0] eD = 32'h0;
    logic [31:0] merged;
    logic [15:0] nc;
    bit          eI = 0, eM = 0;
    if (ok && !wr) eD = (cur >> sh) & msk;
    if (ok && wr) begin
      merged = (cur & ~(msk << sh)) | ((data & msk) << sh);
      case (idx)
        4'd1: begin
          nc = merged[15:0];
          if (!ioPres) nc[0] = 1'b0;
          eI = nc[0] != mCmd[0];
          eM = nc[1] != mCmd[1];
          mCmd = nc;
        end
        4'd4: mBar0 = merged;
        4'd5: mBar1 = merged;
        4'd6: mBus = merged;
        4'd7: begin mIoB = merged[7:0] | 8'h01; mIoL = merged[15:8] | 8'h01; eI = 1; end
        4'd8: begin mMem = merged; eM = 1; end
        4'd12: begin mIoUp = merged; eI = 1; end
        default: ;
      endcase
    end
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqSize = size; reqWData = data;
    @(negedge clk);
    reqValid = 1'b0;
    compare(tag, 1'b1, !ok, eD, eI, eM);
  endtask

  task automatic idle(input string tag);
    reqValid = 1'b0;
    @(negedge clk);
    compare(tag, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got hung run expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    mCmd = '0; mBar0 = '0; mBar1 = '0; mBus = '0; mMem = '0; mIoUp = '0;
    mIoB = 8'h01; mIoL = 8'h01;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle("R13 idle after reset");

    // R1 reset values
    for (int a = 0; a < 64; a += 4) xact(0, 8'(a), 3'd4, 0, "R1 reset read");

    // R2 read-only words
    xact(1, 8'h00, 3'd4, 32'hFFFF_FFFF, "R2 write id");
    xact(1, 8'h08, 3'd4, 32'h1234_5678, "R2 write class");
    xact(1, 8'h0C, 3'd4, 32'hFFFF_FFFF, "R2 write header");
    xact(0, 8'h00, 3'd4, 0, "R2 id kept");
    xact(0, 8'h08, 3'd4, 0, "R2 class kept");
    xact(0, 8'h0C, 3'd4, 0, "R2 header kept");

    // R3 bus numbers
    xact(1, 8'h18, 3'd4, 32'hAA33_2211, "R3 bus write");
    xact(0, 8'h18, 3'd4, 0, "R3 bus read");

    // R4 BARs
    xact(1, 8'h10, 3'd4, 32'hDEAD_BEEF, "R4 bar0 write");
    xact(1, 8'h14, 3'd4, 32'h0F0F_A5A5, "R4 bar1 write");
    xact(0, 8'h10, 3'd4, 0, "R4 bar0 read");
    xact(0, 8'h14, 3'd4, 0, "R4 bar1 read");

    // R5 / R12 I/O window
    xact(1, 8'h1C, 3'd4, 32'hFFFF_F0E0, "R5 R12 io write");
    xact(0, 8'h1C, 3'd4, 0, "R5 io read");

    // R7 / R12 memory and I/O upper
    xact(1, 8'h20, 3'd4, 32'hFFF0_1230, "R7 R12 mem write");
    xact(1, 8'h30, 3'd4, 32'h00FF_0012, "R7 R12 ioup write");
    xact(0, 8'h20, 3'd4, 0, "R7 mem read");
    xact(0, 8'h30, 3'd4, 0, "R7 ioup read");

    // R11 command toggles, both pulses in one cycle
    xact(1, 8'h04, 3'd4, 32'h0000_0003, "R11 both enables");
    xact(1, 8'h04, 3'd4, 32'h0000_0003, "R11 no toggle");
    xact(1, 8'h04, 3'd4, 32'h0000_0002, "R11 io toggle only");
    xact(1, 8'h05, 3'd1, 32'h0000_0004, "R11 R10 upper byte no pulse");
    xact(1, 8'h04, 3'd1, 32'h0000_0000, "R11 mem toggle only");
    xact(0, 8'h04, 3'd4, 0, "R10 cmd read");

    // R6 no I/O port
    ioPres = 1'b0;
    xact(1, 8'h04, 3'd4, 32'h0000_0003, "R6 R11 io enable suppressed");
    xact(0, 8'h04, 3'd4, 0, "R6 cmd read");
    xact(0, 8'h1C, 3'd4, 0, "R6 io window hidden");
    xact(1, 8'h1C, 3'd2, 32'h0000_4020, "R6 R12 io write hidden");
    ioPres = 1'b1;
    xact(0, 8'h1C, 3'd4, 0, "R5 io visible again");

    // R8 zero words and holes
    xact(1, 8'h24, 3'd4, 32'hFFFF_FFFF, "R8 write 0x24");
    xact(1, 8'h38, 3'd4, 32'hFFFF_FFFF, "R8 write 0x38");
    xact(1, 8'h3C, 3'd4, 32'hFFFF_FFFF, "R8 write 0x3C");
    xact(0, 8'h24, 3'd4, 0, "R8 read 0x24");
    xact(0, 8'h38, 3'd4, 0, "R8 read 0x38");
    xact(0, 8'h3C, 3'd4, 0, "R8 read 0x3C");
    xact(0, 8'h28, 3'd4, 0, "R8 hole 0x28");
    xact(1, 8'h2C, 3'd4, 32'h1, "R8 hole 0x2C");
    xact(1, 8'h34, 3'd4, 32'h1, "R8 hole 0x34");
    xact(1, 8'h58, 3'd4, 32'hFFFF_FFFF, "R8 beyond header");
    xact(0, 8'hFC, 3'd4, 0, "R8 beyond header read");
    xact(0, 8'h18, 3'd4, 0, "R8 bus unchanged");

    // R9 sizes and sub-dword reads
    xact(1, 8'h10, 3'd3, 32'h1, "R9 size 3 write");
    xact(0, 8'h10, 3'd0, 0, "R9 size 0 read");
    xact(1, 8'h12, 3'd4, 32'h0, "R9 misaligned dword");
    xact(0, 8'h10, 3'd4, 0, "R9 bar0 unchanged");
    for (int b = 0; b < 4; b++) xact(0, 8'h18 + 8'(b), 3'd1, 0, "R9 byte read");
    xact(0, 8'h1A, 3'd2, 0, "R9 half read");
    xact(0, 8'h0E, 3'd1, 0, "R9 header type byte");

    // R10 sub-dword writes
    xact(1, 8'h19, 3'd1, 32'hFFFF_FF77, "R10 R3 secbus byte");
    xact(1, 8'h12, 3'd2, 32'h0000_C0DE, "R10 bar0 half");
    xact(1, 8'h21, 3'd1, 32'h0000_0099, "R10 R12 mem byte");
    xact(1, 8'h1D, 3'd1, 32'h0000_0080, "R10 R5 io limit byte");
    xact(0, 8'h10, 3'd4, 0, "R10 bar0 merged");
    xact(0, 8'h18, 3'd4, 0, "R10 bus merged");
    xact(0, 8'h1C, 3'd4, 0, "R10 io merged");
    idle("R13 idle");

    // R13 back-to-back mixed traffic
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 120; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      xact(lfsr[7], {2'b00, lfsr[13:10], lfsr[9:8]}, lfsr[16:14], lfsr ^ 32'h5A5A_0F0F,
           "R13 R10 R11 mixed");
      if (lfsr[20]) idle("R13 gap");
      if (lfsr[23:21] == 3'd0) ioPres = ~ioPres;
    end
    ioPres = 1'b1;
    idle("R13 final idle");
    finish_run();
  end

endmodule